// File: doc/BRIEF.md
# I2C Target Port with SDA-Edge Condition Detect

This block is the target (slave) side of a two-wire I2C bus. It answers one 7-bit address supplied on an input and moves bytes in both directions through a simple strobe interface on the system clock. The address is taken from a port, so the integrator can tie it off or drive it from a register. The block does not oversample the bus. A bus START is captured by a flop clocked on the falling edge of SDA, and a STOP by a flop clocked on the rising edge of SDA. Each of these flops samples SCL as its data input. Shifting of bus bits runs on SCL itself: bits are sampled on the rising edge, and the open-drain SDA enable is updated on the falling edge.

The bus side and the system side cross through toggle signals and a parameterised synchroniser chain. Each completed received byte appears on `rx_data` with a one-cycle `rx_valid`. Each time the target latches a byte from `tx_data` for sending, it emits a one-cycle `tx_ready`. The user then places the next byte on `tx_data`. A `busy` flag follows the bus from START to STOP. A master NACK on a read ends transmission. A repeated START sends the target back to the address phase at any point in a transfer.

Top module: `i2ct_target`

## Requirements
- R1: While `rst_n` is low, `busy`, `rx_valid`, `tx_ready` and `sda_oe` are all 0.
- R2: `busy` becomes 1 after SDA falls while SCL is high (START). It returns to 0 after SDA rises while SCL is high (STOP).
- R3: The first byte after a START is taken MSB first. Its upper 7 bits are compared with `own_addr`, and bit 0 is the direction (1 = target sends, 0 = target receives). On a match, the target drives SDA low (`sda_oe`=1) for the ninth clock.
- R4: On an address mismatch there is no acknowledge. All later bits until the next START are ignored: SDA stays released and neither strobe fires.
- R5: In receive direction, each 8-bit byte is taken MSB first and acknowledged by the target. The byte is presented on `rx_data` with `rx_valid` high for exactly one clock cycle.
- R6: In send direction, the target shifts out the byte it latched from `tx_data`, MSB first. Each latch produces a `tx_ready` pulse exactly one clock cycle wide. The first byte must be on `tx_data` before the address acknowledge ends.
- R7: After a sent byte, a master ACK (SDA low in the ninth clock) makes the target latch and send the next byte. A master NACK (SDA high) makes it release SDA and send nothing more until the next START.
- R8: A repeated START, issued without a STOP, restarts the address phase from any state. The new address byte may select either direction.
- R9: `sda_oe` changes only while SCL is low.
- R10: `sda_oe` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the strobe interface and busy flag |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| tx_data | input | 8 | Next byte to send during a read |
| tx_ready | output | 1 | One-cycle pulse: a byte was latched from tx_data |
| rx_data | output | 8 | Last byte received during a write |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new byte |
| busy | output | 1 | Bus is between a START and a STOP |

## Verification
The bench builds the target with the default two-stage synchroniser and address 0x3C. It runs the bus at 80 system cycles per SCL bit. This spacing lets busy, rx_valid and tx_ready settle well inside a single bit, so every strobe can be counted between bus events. A vector table covers match and mismatch in both directions, including an address that differs only in its MSB. Directed runs then cover multi-byte bursts, master ACK versus NACK, and repeated STARTs after a write and after a rejected address. Synchroniser depths above two are elaborated but not exercised against slower bus timing.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_AACK,
      PH_RX,
      PH_RACK,
      PH_TX,
      PH_TACK
   } phase_t;
endpackage

// File: rtl/i2ct_cond_detect.sv
module i2ct_cond_detect (
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_flag,
   output logic stop_flag
);
   logic start_q;
   logic stop_q;
   logic start_rst_n;
   logic stop_rst_n;

   // A START flag cannot survive SCL going low; a STOP flag is wiped by a START.
   assign start_rst_n = rst_n & scl_i;
   assign stop_rst_n  = rst_n & ~start_q;

   always_ff @(negedge sda_i or negedge start_rst_n) begin
      if (!start_rst_n) start_q <= 1'b0;
      else              start_q <= scl_i;
   end

   always_ff @(posedge sda_i or negedge stop_rst_n) begin
      if (!stop_rst_n) stop_q <= 1'b0;
      else             stop_q <= scl_i;
   end

   assign start_flag = start_q;
   assign stop_flag  = stop_q;
endmodule

// File: rtl/i2ct_bit_engine.sv
module i2ct_bit_engine
   import i2ct_pkg::*;
(
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              start_flag,
   input  logic              stop_flag,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_tgl,
   output logic              tx_tgl
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

   logic              eng_rst_n;
   logic [BYTE_W-1:0] shreg;
   phase_t            phase, phase_n;
   logic [CNT_W-1:0]  cnt, cnt_n;
   logic              oe_q, oe_n;
   logic              rw_q, rw_n;
   logic [BYTE_W-1:0] txsh, txsh_n;
   logic              ev_rx, ev_load;
   logic              addr_hit;

   assign eng_rst_n = rst_n & ~stop_flag;
   assign addr_hit  = (shreg[BYTE_W-1:1] == own_addr);

   // Sampling side: every SCL rise shifts the line in.
   always_ff @(posedge scl_i or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[BYTE_W-2:0], sda_i};
   end

   always_comb begin
      phase_n = phase;
      cnt_n   = cnt;
      oe_n    = oe_q;
      rw_n    = rw_q;
      txsh_n  = txsh;
      ev_rx   = 1'b0;
      ev_load = 1'b0;
      if (start_flag) begin
         phase_n = PH_ADDR;
         cnt_n   = '0;
         oe_n    = 1'b0;
      end else begin
         unique case (phase)
            PH_ADDR: begin
               if (cnt == LAST_BIT) begin
                  if (addr_hit) begin
                     phase_n = PH_AACK;
                     oe_n    = 1'b1;
                     rw_n    = shreg[0];
                  end else begin
                     phase_n = PH_IDLE;
                     oe_n    = 1'b0;
                  end
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            PH_AACK: begin
               if (rw_q) begin
                  ev_load = 1'b1;
               end else begin
                  phase_n = PH_RX;
                  cnt_n   = '0;
                  oe_n    = 1'b0;
               end
            end
            PH_RX: begin
               if (cnt == LAST_BIT) begin
                  phase_n = PH_RACK;
                  oe_n    = 1'b1;
                  ev_rx   = 1'b1;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            PH_RACK: begin
               phase_n = PH_RX;
               cnt_n   = '0;
               oe_n    = 1'b0;
            end
            PH_TX: begin
               if (cnt == ALL_BITS) begin
                  phase_n = PH_TACK;
                  oe_n    = 1'b0;
               end else begin
                  oe_n   = ~txsh[BYTE_W-1];
                  txsh_n = {txsh[BYTE_W-2:0], 1'b0};
                  cnt_n  = cnt + 1'b1;
               end
            end
            PH_TACK: begin
               if (shreg[0]) begin
                  phase_n = PH_IDLE;
                  oe_n    = 1'b0;
               end else begin
                  ev_load = 1'b1;
               end
            end
            default: begin
               phase_n = PH_IDLE;
               oe_n    = 1'b0;
            end
         endcase
         if (ev_load) begin
            phase_n = PH_TX;
            oe_n    = ~tx_data[BYTE_W-1];
            txsh_n  = {tx_data[BYTE_W-2:0], 1'b0};
            cnt_n   = CNT_W'(1);
         end
      end
   end

   // Driving side: all state moves on SCL falls; a STOP holds it idle.
   always_ff @(negedge scl_i or negedge eng_rst_n) begin
      if (!eng_rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         oe_q  <= 1'b0;
         rw_q  <= 1'b0;
         txsh  <= '0;
      end else begin
         phase <= phase_n;
         cnt   <= cnt_n;
         oe_q  <= oe_n;
         rw_q  <= rw_n;
         txsh  <= txsh_n;
      end
   end

   // Toggles must not be disturbed by STOP, or a false strobe would appear.
   always_ff @(negedge scl_i or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte <= '0;
         rx_tgl  <= 1'b0;
         tx_tgl  <= 1'b0;
      end else begin
         if (ev_rx) begin
            rx_byte <= shreg;
            rx_tgl  <= ~rx_tgl;
         end
         if (ev_load) tx_tgl <= ~tx_tgl;
      end
   end

   assign sda_oe = oe_q;
endmodule

// File: rtl/i2ct_level_sync.sv
module i2ct_level_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_chk
      $error("i2ct_level_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stage[g-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
   import i2ct_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              tx_ready,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy
);
   localparam int XW = 4;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("i2ct_target: SYNC_STAGES must be 2..4");
   end
   if (BYTE_W != ADDR_W + 1) begin : g_bad_fmt
      $error("i2ct_target: address plus direction must fill one byte");
   end

   logic              start_flag, stop_flag;
   logic [BYTE_W-1:0] rx_byte;
   logic              rx_tgl, tx_tgl;
   logic [XW-1:0]     xs;
   logic              rx_seen, tx_seen;

   i2ct_cond_detect u_cond (
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .start_flag (start_flag),
      .stop_flag  (stop_flag)
   );

   i2ct_bit_engine u_eng (
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .start_flag (start_flag),
      .stop_flag  (stop_flag),
      .own_addr   (own_addr),
      .tx_data    (tx_data),
      .sda_oe     (sda_oe),
      .rx_byte    (rx_byte),
      .rx_tgl     (rx_tgl),
      .tx_tgl     (tx_tgl)
   );

   i2ct_level_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({tx_tgl, rx_tgl, stop_flag, start_flag}),
      .q     (xs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_seen  <= 1'b0;
         tx_seen  <= 1'b0;
         rx_valid <= 1'b0;
         tx_ready <= 1'b0;
         rx_data  <= '0;
         busy     <= 1'b0;
      end else begin
         rx_seen  <= xs[2];
         tx_seen  <= xs[3];
         rx_valid <= xs[2] ^ rx_seen;
         tx_ready <= xs[3] ^ tx_seen;
         if (xs[2] ^ rx_seen) rx_data <= rx_byte;
         if (xs[0])      busy <= 1'b1;
         else if (xs[1]) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/i2ct_target_chk.sv
module i2ct_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic rx_valid,
   input logic tx_ready,
   input logic busy
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!busy && !rx_valid && !tx_ready && !sda_oe);
      end
   end

   a_r5_rx_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   a_r6_tx_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |=> !tx_ready);

   a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_oe);
endmodule

bind i2ct_target i2ct_target_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_oe   (sda_oe),
   .rx_valid (rx_valid),
   .tx_ready (tx_ready),
   .busy     (busy)
);

// File: tb/i2ct_target_test.sv
`timescale 1ns/1ps
module i2ct_target_test;
   localparam int Q = 100;
   localparam logic [6:0] OWN = 7'h3C;
   // {address, direction, data, expected acknowledge}
   localparam logic [16:0] VEC [7] = '{
      {7'h3C, 1'b0, 8'hA5, 1'b1},
      {7'h3C, 1'b1, 8'hC3, 1'b1},
      {7'h3D, 1'b0, 8'hFF, 1'b0},
      {7'h3C, 1'b0, 8'h00, 1'b1},
      {7'h1E, 1'b1, 8'h55, 1'b0},
      {7'h3C, 1'b1, 8'h5A, 1'b1},
      {7'h7C, 1'b0, 8'h3C, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_oe, tx_ready, rx_valid, busy;
   logic [7:0] rx_data, tx_data;
   logic [7:0] tx_q [8];
   int tx_base = 0;
   int rx_cnt = 0, tx_cnt = 0, wide_bad = 0, r9_bad = 0, r10_bad = 0;
   logic [7:0] rx_last = 8'h00;
   logic rx_prev = 1'b0, tx_prev = 1'b0, oe_prev = 1'b0;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;
   assign tx_data = tx_q[(tx_cnt - tx_base) & 7];

   i2ct_target uut (
      .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
   );

   always @(negedge clk) begin
      if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
      if (tx_ready) tx_cnt++;
      if ((rx_valid && rx_prev) || (tx_ready && tx_prev)) wide_bad++;
      if (rst_n && sda_oe !== oe_prev && scl_m) r9_bad++;
      if (rst_n && sda_oe && !busy) r10_bad++;
      rx_prev = rx_valid; tx_prev = tx_ready; oe_prev = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
   endtask
   task automatic bus_stop();
      sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q; #Q;
   endtask
   task automatic send_bit(input logic b);
      sda_m = b; #Q; scl_m = 1'b1; #Q; #Q; scl_m = 1'b0; #Q;
   endtask
   task automatic recv_bit(output logic b);
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_bus; #Q; scl_m = 1'b0; #Q;
   endtask
   task automatic write_byte(input logic [7:0] v, output bit acked);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      acked = !a;
   endtask
   task automatic read_byte(output logic [7:0] v, input logic nack);
      for (int i = 7; i >= 0; i--) recv_bit(v[i]);
      send_bit(nack);
   endtask

   initial begin
      #400_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit ack, ack2;
      logic [7:0] got;
      logic [6:0] a;
      logic rw, ea;
      logic [7:0] d;
      int rx0, tx0;
      for (int i = 0; i < 8; i++) tx_q[i] = 8'h00;
      #10 rst_n = 1'b0;
      #20;
      chk(!busy && !rx_valid && !tx_ready && !sda_oe, "R1 reset quiet",
          {busy, rx_valid, tx_ready, sda_oe}, 0);
      #80 rst_n = 1'b1;
      #100;
      chk(!busy && !sda_oe && rx_cnt == 0, "R1 after release", {busy, sda_oe}, 0);

      // Vector table
      for (int v = 0; v < 7; v++) begin
         {a, rw, d, ea} = VEC[v];
         if (rw) begin tx_q[0] = d; tx_base = tx_cnt; end
         rx0 = rx_cnt; tx0 = tx_cnt;
         bus_start();
         chk(busy, "R2 busy after start", busy, 1);
         write_byte({a, rw}, ack);
         chk(ack == ea, ea ? "R3 address ack" : "R4 address no ack", ack, ea);
         if (!rw) begin
            write_byte(d, ack2);
            if (ea) begin
               chk(ack2, "R5 data ack", ack2, 1);
               chk(rx_cnt == rx0 + 1, "R5 one rx strobe", rx_cnt - rx0, 1);
               chk(rx_last == d, "R5 rx byte", rx_last, d);
            end else begin
               chk(!ack2, "R4 data ignored", ack2, 0);
               chk(rx_cnt == rx0, "R4 no rx strobe", rx_cnt - rx0, 0);
            end
         end else begin
            read_byte(got, 1'b1);
            if (ea) begin
               chk(got == d, "R6 tx byte", got, d);
               chk(tx_cnt == tx0 + 1, "R7 nack stops loads", tx_cnt - tx0, 1);
            end else begin
               chk(got == 8'hFF, "R4 read released", got, 8'hFF);
               chk(tx_cnt == tx0, "R4 no tx strobe", tx_cnt - tx0, 0);
            end
         end
         bus_stop();
         chk(!busy, "R2 busy cleared by stop", busy, 0);
      end

      // Multi-byte write
      rx0 = rx_cnt;
      bus_start();
      write_byte({OWN, 1'b0}, ack);
      chk(ack, "R3 burst write address", ack, 1);
      write_byte(8'h12, ack2); chk(ack2 && rx_last == 8'h12, "R5 burst byte 0", rx_last, 8'h12);
      write_byte(8'h34, ack2); chk(ack2 && rx_last == 8'h34, "R5 burst byte 1", rx_last, 8'h34);
      write_byte(8'h56, ack2); chk(ack2 && rx_last == 8'h56, "R5 burst byte 2", rx_last, 8'h56);
      chk(rx_cnt == rx0 + 3, "R5 three strobes", rx_cnt - rx0, 3);
      bus_stop();

      // Multi-byte read: ACK, ACK, NACK
      tx_q[0] = 8'h81; tx_q[1] = 8'h7E; tx_q[2] = 8'hF0; tx_q[3] = 8'h0F;
      tx_base = tx_cnt; tx0 = tx_cnt;
      bus_start();
      write_byte({OWN, 1'b1}, ack);
      chk(ack, "R3 burst read address", ack, 1);
      read_byte(got, 1'b0); chk(got == 8'h81, "R6 read byte 0", got, 8'h81);
      read_byte(got, 1'b0); chk(got == 8'h7E, "R7 ack continues", got, 8'h7E);
      read_byte(got, 1'b1); chk(got == 8'hF0, "R6 read byte 2", got, 8'hF0);
      chk(tx_cnt == tx0 + 3, "R7 no load after nack", tx_cnt - tx0, 3);
      recv_bit(got[0]);
      chk(got[0] == 1'b1 && !sda_oe, "R7 released after nack", got[0], 1);
      bus_stop();

      // Repeated START: write then read
      bus_start();
      write_byte({OWN, 1'b0}, ack);
      write_byte(8'h11, ack2);
      chk(rx_last == 8'h11, "R8 write before restart", rx_last, 8'h11);
      tx_q[0] = 8'h22; tx_base = tx_cnt;
      bus_start();
      chk(busy, "R8 busy through restart", busy, 1);
      write_byte({OWN, 1'b1}, ack);
      chk(ack, "R8 restart address ack", ack, 1);
      read_byte(got, 1'b1);
      chk(got == 8'h22, "R8 read after restart", got, 8'h22);
      bus_stop();

      // Repeated START after a rejected address
      rx0 = rx_cnt;
      bus_start();
      write_byte({7'h11, 1'b0}, ack);
      chk(!ack, "R4 foreign address", ack, 0);
      bus_start();
      write_byte({OWN, 1'b0}, ack);
      chk(ack, "R8 restart after mismatch", ack, 1);
      write_byte(8'h99, ack2);
      chk(ack2 && rx_last == 8'h99 && rx_cnt == rx0 + 1, "R8 data after mismatch", rx_last, 8'h99);
      bus_stop();

      #200;
      chk(wide_bad == 0, "R5 R6 strobes one cycle", wide_bad, 0);
      chk(r9_bad == 0, "R9 sda_oe steady while SCL high", r9_bad, 0);
      chk(r10_bad == 0, "R10 released while idle", r10_bad, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule